// File: doc/BRIEF.md
# Binary32 to 32-bit Integer Converter

This block turns a single-precision floating-point word into a 32-bit integer. A per-operand select chooses between a signed (two's complement) result and an unsigned result. The rounding direction comes from a 2-bit mode input, unless a truncate input is raised, which forces rounding toward zero whatever the mode says. Beside the integer, the block reports three flags: invalid, inexact, and input-denormal.

Each operand goes through one combinational datapath and is captured in a single register stage. A result appears one clock after the accepted operand, with `out_valid` high. When no operand is offered, the output register keeps its value. Out-of-range values and NaNs saturate in a fixed way that depends on the signedness. Magnitudes below one follow their own directed-rounding rules.

Top module: `f2i_conv`

## Requirements
- R1: `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and low otherwise. Reset clears `out_valid`, `out_int` and all flags to zero.
- R2: `out_denorm` is raised when the operand exponent field is zero and its fraction field is nonzero.
- R3: A NaN (exponent all ones, fraction nonzero) gives 0 in signed mode and 0xFFFFFFFF in unsigned mode, with invalid in both modes.
- R4: A non-NaN operand with biased exponent 159 or more (this includes infinities) raises invalid. Signed mode gives 0x7FFFFFFF for positive operands and 0x80000000 for negative ones. Unsigned mode gives 0xFFFFFFFF for positive operands and 0 for negative ones.
- R5: For biased exponents 126 to 158, the magnitude is rounded according to `in_rmode`: 2'b00 is nearest with ties to even, 2'b01 is toward plus infinity, 2'b10 is toward minus infinity, 2'b11 is toward zero.
- R6: In unsigned mode, a negative operand whose rounded magnitude is nonzero gives 0 with invalid. No negative operand ever gives a nonzero unsigned result.
- R7: In signed mode, a rounded magnitude above 0x7FFFFFFF (positive operand) or above 0x80000000 (negative operand) saturates to 0x7FFFFFFF or 0x80000000 with invalid. Otherwise a negative operand returns the two's complement of the magnitude.
- R8: When the discarded fraction is nonzero, inexact is raised, except on the 126-to-158 path when that path reports invalid.
- R9: A nonzero operand with biased exponent below 126 gives inexact and a result of 0. There are two exceptions: toward-plus with a positive operand gives 1, and toward-minus with a negative operand gives 0xFFFFFFFF when signed, or 0 with invalid when unsigned.
- R10: When `in_trunc` is high, `in_rmode` has no effect and the result is that of mode 2'b11.
- R11: +0 and -0 give 0 with invalid, inexact and denormal all low.
- R12: In a cycle with `in_valid` low, `out_int` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_word | input | 32 | Binary32 operand: sign bit 31, exponent 30:23, fraction 22:0 |
| in_signed | input | 1 | 1 selects a signed result, 0 an unsigned result |
| in_trunc | input | 1 | 1 forces rounding toward zero |
| in_rmode | input | 2 | Rounding mode, encoded as in R5 |
| out_valid | output | 1 | Result present |
| out_int | output | 32 | Converted integer |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |
| out_denorm | output | 1 | Input-denormal flag |

## Verification
The assertions assume that `in_valid`, `in_word`, `in_signed` and `in_trunc` are driven to known values in every cycle from reset onward. They also assume the operand fields do not change between the sampling edge and the cycle the result is checked. The bench meets both assumptions by driving every input on the falling clock edge, starting with all-zero values during reset. The stimulus is spread over these cases:
- exponents around the 126 and 159 thresholds, plus denormals, zeros, infinities and NaNs;
- all four modes in both signedness choices, with truncation raised on about a quarter of the operands;
- gaps in `in_valid`, so the hold behaviour is exercised between results.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    // Rounding direction encoding seen on the mode input.
    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_UP   = 2'b01,
        RM_DOWN = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    // Which conversion path a finite operand takes, by magnitude.
    typedef enum logic [1:0] {
        MAG_SMALL = 2'b00,
        MAG_MID   = 2'b01,
        MAG_BIG   = 2'b10
    } mag_e;

endpackage

// File: rtl/f2i_classify.sv
module f2i_classify
    import f2i_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 32
) (
    input  logic [EXP_W+MAN_W:0] word_i,
    output logic                 sign_o,
    output logic [EXP_W-1:0]     exp_o,
    output logic [MAN_W-1:0]     frac_o,
    output logic                 nan_o,
    output logic                 denorm_o,
    output logic                 nonzero_o,
    output mag_e                 mag_o
);

    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic [EXP_W:0] BIG_E = (EXP_W + 1)'(BIAS + INT_W);
    localparam logic [EXP_W:0] LOW_E = (EXP_W + 1)'(BIAS - 1);

    always_comb begin
        sign_o    = word_i[EXP_W+MAN_W];
        exp_o     = word_i[EXP_W+MAN_W-1:MAN_W];
        frac_o    = word_i[MAN_W-1:0];
        nan_o     = (&exp_o) && (|frac_o);
        denorm_o  = (exp_o == '0) && (|frac_o);
        nonzero_o = (|exp_o) || (|frac_o);
        if ({1'b0, exp_o} >= BIG_E) begin
            mag_o = MAG_BIG;
        end else if ({1'b0, exp_o} >= LOW_E) begin
            mag_o = MAG_MID;
        end else begin
            mag_o = MAG_SMALL;
        end
    end

endmodule

// File: rtl/f2i_align.sv
module f2i_align #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 32
) (
    input  logic [EXP_W-1:0] exp_i,
    input  logic [MAN_W-1:0] frac_i,
    output logic [INT_W-1:0] int_o,
    output logic [INT_W-1:0] rem_o
);

    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int TOP_E = BIAS + INT_W - 1;
    localparam int SH_W  = $clog2(INT_W + 1);

    logic [INT_W-1:0]   norm;
    logic [EXP_W:0]     diff;
    logic [SH_W-1:0]    sh;
    logic [2*INT_W-1:0] wide;

    // Left-justify the significand (with its hidden one) in the integer width.
    generate
        if (INT_W > MAN_W + 1) begin : g_pad
            assign norm = {1'b1, frac_i, {(INT_W - MAN_W - 1){1'b0}}};
        end else begin : g_exact
            assign norm = {1'b1, frac_i};
        end
    endgenerate

    initial begin
        if (INT_W < MAN_W + 1) $display("f2i_align: integer width narrower than significand");
    end

    always_comb begin
        diff = (EXP_W + 1)'(TOP_E) - {1'b0, exp_i};
        if ({1'b0, exp_i} > (EXP_W + 1)'(TOP_E)) begin
            sh = '0;
        end else if (diff > (EXP_W + 1)'(INT_W)) begin
            sh = SH_W'(INT_W);
        end else begin
            sh = diff[SH_W-1:0];
        end
        wide  = {norm, {INT_W{1'b0}}} >> sh;
        int_o = wide[2*INT_W-1:INT_W];
        rem_o = wide[INT_W-1:0];
    end

endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic [INT_W-1:0] int_i,
    input  logic [INT_W-1:0] rem_i,
    input  logic             sign_i,
    input  rmode_e           rmode_i,
    input  logic             signed_i,
    input  mag_e             mag_i,
    input  logic             nan_i,
    input  logic             nonzero_i,
    output logic [INT_W-1:0] res_o,
    output logic             invalid_o,
    output logic             inexact_o
);

    localparam logic [INT_W-1:0] ALL1 = {INT_W{1'b1}};
    localparam logic [INT_W-1:0] HALF = {1'b1, {(INT_W - 1){1'b0}}};
    localparam logic [INT_W-1:0] SMAX = {1'b0, {(INT_W - 1){1'b1}}};
    localparam logic [INT_W-1:0] ONE  = INT_W'(1);

    logic [INT_W-1:0] incr;
    logic [INT_W:0]   rsum;
    logic             carry;
    logic [INT_W-1:0] mag_v;
    logic             bump_ovf;
    logic [INT_W-1:0] limit;

    always_comb begin
        unique case (rmode_i)
            RM_NEAR: incr = int_i[0] ? HALF : HALF - ONE;
            RM_UP:   incr = sign_i ? '0 : ALL1;
            RM_DOWN: incr = sign_i ? ALL1 : '0;
            RM_ZERO: incr = '0;
            default: incr = '0;
        endcase
        rsum  = {1'b0, rem_i} + {1'b0, incr};
        carry = rsum[INT_W];

        bump_ovf = 1'b0;
        mag_v    = int_i;
        if (carry) begin
            if (int_i != ALL1) begin
                mag_v = int_i + ONE;
            end else begin
                bump_ovf = 1'b1;
            end
        end
        limit = sign_i ? HALF : SMAX;

        res_o     = '0;
        invalid_o = 1'b0;
        inexact_o = 1'b0;
        if (nan_i) begin
            res_o     = signed_i ? '0 : ALL1;
            invalid_o = 1'b1;
        end else if (mag_i == MAG_BIG) begin
            invalid_o = 1'b1;
            if (signed_i) begin
                res_o = sign_i ? HALF : SMAX;
            end else begin
                res_o = sign_i ? '0 : ALL1;
            end
        end else if (mag_i == MAG_MID) begin
            if (!signed_i) begin
                if (sign_i && (mag_v != '0)) begin
                    invalid_o = 1'b1;
                end else begin
                    res_o     = mag_v;
                    invalid_o = bump_ovf;
                    inexact_o = (rem_i != '0) && !bump_ovf;
                end
            end else begin
                if (mag_v > limit) begin
                    res_o     = limit;
                    invalid_o = 1'b1;
                end else begin
                    res_o     = sign_i ? (~mag_v + ONE) : mag_v;
                    inexact_o = (rem_i != '0);
                end
            end
        end else if (nonzero_i) begin
            inexact_o = 1'b1;
            if ((rmode_i == RM_UP) && !sign_i) begin
                res_o = ONE;
            end else if ((rmode_i == RM_DOWN) && sign_i) begin
                if (signed_i) begin
                    res_o = ALL1;
                end else begin
                    invalid_o = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
    import f2i_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [EXP_W+MAN_W:0] in_word,
    input  logic                 in_signed,
    input  logic                 in_trunc,
    input  logic [1:0]           in_rmode,
    output logic                 out_valid,
    output logic [INT_W-1:0]     out_int,
    output logic                 out_invalid,
    output logic                 out_inexact,
    output logic                 out_denorm
);

    localparam int FW   = EXP_W + MAN_W;
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic [EXP_W:0] SAT_E = (EXP_W + 1)'(BIAS + INT_W);

    typedef struct packed {
        logic             valid;
        logic [INT_W-1:0] value;
        logic             invalid;
        logic             inexact;
        logic             denorm;
    } out_t;

    out_t st_d, st_q;

    logic             c_sign, c_nan, c_den, c_nz;
    logic [EXP_W-1:0] c_exp;
    logic [MAN_W-1:0] c_frac;
    mag_e             c_mag;
    logic [INT_W-1:0] a_int, a_rem;
    logic [INT_W-1:0] r_val;
    logic             r_inv, r_inx;
    rmode_e           rm_eff;

    assign rm_eff = in_trunc ? RM_ZERO : rmode_e'(in_rmode);

    f2i_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_cls (
        .word_i    (in_word),
        .sign_o    (c_sign),
        .exp_o     (c_exp),
        .frac_o    (c_frac),
        .nan_o     (c_nan),
        .denorm_o  (c_den),
        .nonzero_o (c_nz),
        .mag_o     (c_mag)
    );

    f2i_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_aln (
        .exp_i  (c_exp),
        .frac_i (c_frac),
        .int_o  (a_int),
        .rem_o  (a_rem)
    );

    f2i_round #(.INT_W(INT_W)) u_rnd (
        .int_i     (a_int),
        .rem_i     (a_rem),
        .sign_i    (c_sign),
        .rmode_i   (rm_eff),
        .signed_i  (in_signed),
        .mag_i     (c_mag),
        .nan_i     (c_nan),
        .nonzero_i (c_nz),
        .res_o     (r_val),
        .invalid_o (r_inv),
        .inexact_o (r_inx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.value   = r_val;
            st_d.invalid = r_inv;
            st_d.inexact = r_inx;
            st_d.denorm  = c_den;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_int     = st_q.value;
    assign out_invalid = st_q.invalid;
    assign out_inexact = st_q.inexact;
    assign out_denorm  = st_q.denorm;

    // Operand decode seen directly from the port, for the checks below.
    logic [EXP_W-1:0] in_exp;
    logic             in_nan;
    assign in_exp = in_word[FW-1:MAN_W];
    assign in_nan = (&in_exp) && (|in_word[MAN_W-1:0]);

    p_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_denorm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_denorm == $past((in_exp == '0) && (in_word[MAN_W-1:0] != '0))));
    p_nan_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_nan |=> out_invalid &&
            (out_int == ($past(in_signed) ? INT_W'(0) : {INT_W{1'b1}})));
    p_big_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_nan && ({1'b0, in_exp} >= SAT_E) |=> out_invalid);
    p_uneg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_signed && in_word[FW] && !in_nan |=> (out_int == '0));
    p_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_word[FW-1:0] == '0) |=>
            (out_int == '0) && !out_invalid && !out_inexact && !out_denorm);
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_int));

endmodule

// File: tb/tb_f2i_conv.sv
module tb_f2i_conv;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_signed = 1'b0;
    logic        in_trunc = 1'b0;
    logic [1:0]  in_rmode = 2'b00;
    logic        out_valid;
    logic [31:0] out_int;
    logic        out_invalid, out_inexact, out_denorm;

    always #5 clk = ~clk;

    f2i_conv dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_signed(in_signed), .in_trunc(in_trunc), .in_rmode(in_rmode),
        .out_valid(out_valid), .out_int(out_int), .out_invalid(out_invalid),
        .out_inexact(out_inexact), .out_denorm(out_denorm)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Expected result queue: one entry per accepted operand.
    logic [31:0] exp_q_int[$];
    bit          exp_q_inv[$], exp_q_inx[$], exp_q_den[$];
    string       exp_q_tag[$];
    bit          pend = 0;
    logic [31:0] last_int = '0;

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Behavioural reference: value = {1,frac} * 2^(e-150), worked in 64-bit integers.
    function automatic void model(input logic [31:0] w, input bit sg, input bit tr,
                                  input bit [1:0] rm, output logic [31:0] r,
                                  output bit inv, output bit inx, output bit den,
                                  output string tag);
        int e;
        bit s, nan;
        int mode;
        longint unsigned m, ip, rr, half, mag;
        int sh;
        bit up;
        e    = int'(w[30:23]);
        s    = w[31];
        m    = {40'd0, 1'b1, w[22:0]};
        nan  = (e == 255) && (w[22:0] != 0);
        mode = tr ? 3 : int'(rm);
        den  = (e == 0) && (w[22:0] != 0);
        inv  = 0;
        inx  = 0;
        r    = '0;
        tag  = "R5";
        if (nan) begin
            tag = "R3";
            r   = sg ? 32'h0 : 32'hFFFF_FFFF;
            inv = 1;
        end else if (e >= 159) begin
            tag = "R4";
            inv = 1;
            if (sg) r = s ? 32'h8000_0000 : 32'h7FFF_FFFF;
            else    r = s ? 32'h0 : 32'hFFFF_FFFF;
        end else if (e == 0 && w[22:0] == 0) begin
            tag = "R11";
        end else if (e < 126) begin
            tag = "R9";
            inx = 1;
            if (mode == 1 && !s) r = 32'd1;
            else if (mode == 2 && s) begin
                if (sg) r = 32'hFFFF_FFFF;
                else    inv = 1;
            end
        end else begin
            sh = 150 - e;
            if (sh <= 0) begin
                ip = m << (-sh);
                rr = 0;
                half = 0;
            end else begin
                ip   = m >> sh;
                rr   = m & ((64'd1 << sh) - 1);
                half = 64'd1 << (sh - 1);
            end
            case (mode)
                0: up = (rr > half) || (rr == half && rr != 0 && ip[0]);
                1: up = (rr != 0) && !s;
                2: up = (rr != 0) && s;
                default: up = 0;
            endcase
            mag = ip + (up ? 64'd1 : 64'd0);
            if (!sg) begin
                tag = s ? "R6" : "R5 R8";
                if (s && mag != 0) inv = 1;
                else if (mag > 64'hFFFF_FFFF) begin inv = 1; r = 32'hFFFF_FFFF; end
                else r = mag[31:0];
            end else begin
                tag = "R7 R8";
                if (mag > (s ? 64'h8000_0000 : 64'h7FFF_FFFF)) begin
                    inv = 1;
                    r   = s ? 32'h8000_0000 : 32'h7FFF_FFFF;
                end else begin
                    r = s ? 32'(64'd0 - mag) : mag[31:0];
                end
            end
            inx = (rr != 0) && !inv;
            if (tr) tag = {tag, " R10"};
        end
    endfunction

    task automatic step(bit v, logic [31:0] w, bit sg, bit tr, bit [1:0] rm);
        logic [31:0] er;
        bit ei, ex, ed;
        string tg;
        @(negedge clk);
        chk(out_valid == pend, "R1", "out_valid", 64'(out_valid), 64'(pend));
        if (pend) begin
            er = exp_q_int.pop_front();
            ei = exp_q_inv.pop_front();
            ex = exp_q_inx.pop_front();
            ed = exp_q_den.pop_front();
            tg = exp_q_tag.pop_front();
            chk(out_int == er && out_invalid == ei && out_inexact == ex, tg,
                "{invalid,inexact,int}", {30'd0, out_invalid, out_inexact, out_int},
                {30'd0, ei, ex, er});
            chk(out_denorm == ed, "R2", "denorm flag", 64'(out_denorm), 64'(ed));
        end else begin
            chk(out_int == last_int, "R12", "hold", 64'(out_int), 64'(last_int));
        end
        last_int  = out_int;
        in_valid  = v;
        in_word   = w;
        in_signed = sg;
        in_trunc  = tr;
        in_rmode  = rm;
        pend      = v;
        if (v) begin
            model(w, sg, tr, rm, er, ei, ex, ed, tg);
            exp_q_int.push_back(er);
            exp_q_inv.push_back(ei);
            exp_q_inx.push_back(ex);
            exp_q_den.push_back(ed);
            exp_q_tag.push_back(tg);
        end
    endtask

    logic [31:0] dir [22] = '{
        32'h3FC0_0000, 32'h4020_0000, 32'hC020_0000, 32'h3F00_0000,
        32'h3F33_3333, 32'hBF33_3333, 32'h4F00_0000, 32'hCF00_0000,
        32'h4F80_0000, 32'h4F7F_FFFF, 32'h7FC0_0000, 32'hFF80_0001,
        32'h7F80_0000, 32'hFF80_0000, 32'h0000_0001, 32'h8000_0001,
        32'h0000_0000, 32'h8000_0000, 32'h3E80_0000, 32'hBE80_0000,
        32'hBFC0_0000, 32'h3FD9_999A
    };

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 0 && out_int == 0 && !out_invalid && !out_inexact && !out_denorm,
            "R1", "reset state", {27'd0, out_valid, out_invalid, out_inexact, out_denorm, 1'b0, out_int},
            64'd0);
        for (int i = 0; i < 22; i++) begin
            for (int c = 0; c < 16; c++) begin
                step(1'b1, dir[i], c[0], c[1], c[3:2]);
            end
            step(1'b0, 32'h3FC0_0000, 1'b1, 1'b0, 2'b01);
        end
        for (int i = 0; i < 5000; i++) begin
            logic [31:0] w;
            int k;
            w = $urandom;
            k = $urandom_range(0, 9);
            if (k < 7)       w[30:23] = 8'($urandom_range(120, 162));
            else if (k == 7) w[30:23] = 8'($urandom_range(0, 1));
            if ($urandom_range(0, 3) == 0) w[10:0] = '0;
            step($urandom_range(0, 5) != 0, w, 1'($urandom_range(0, 1)),
                 $urandom_range(0, 3) == 0, 2'($urandom_range(0, 3)));
        end
        step(1'b0, 32'h0, 1'b0, 1'b0, 2'b00);
        step(1'b0, 32'h0, 1'b0, 1'b0, 2'b00);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule